// File: doc/BRIEF.md
# Shared Successive-Approximation Row Converter Controller

This block sequences a whole row of column analog-to-digital converters at once. Each column has only a comparator and an 8-bit code register, and that register drives the column's resistor-string DAC. One shared sequencer walks every column through the same bit positions in lock-step. Each column register reacts only to its own comparator bit.

Each conversion starts with a comparator-offset calibration window. Its length in cycles is programmable. Eight bit-decision cycles follow, from MSB to LSB. The results then stay on the DAC code outputs until the next start.

The same column registers also serve the opposite direction, digital-to-analog input. In that mode a host loads a full row of codes, and the codes pass unchanged to the DAC code outputs. The comparators play no part in this mode.

Top module: `sar_row_ctrl`

## Requirements
- R1: After reset every column code is 0, and `busy_o`, `done_o` and `cal_o` are low.
- R2: A `start_i` pulse is accepted when `dac_mode_i` is low and no conversion is running. On acceptance every column code is cleared to 0 and `cal_o` goes high for max(`cal_cycles_i`,1) cycles, with the codes held at 0.
- R3: After calibration come exactly eight decision cycles, one per bit, MSB (bit 7) first. In the cycle that decides bit k, a column's code has bit k set to 1, the bits above k already resolved, and the bits below k at 0.
- R4: A trial bit is kept when the column's comparator bit is 1 (analog input at or above the DAC level). Otherwise it is cleared. With an ideal comparator the final code equals the column's 8-bit input level.
- R5: All columns convert in parallel and independently. Column c occupies bits [8c+7:8c] of `dac_code_o` and of `load_code_i`.
- R6: `busy_o` is high through calibration and the bit decisions. `done_o` rises max(`cal_cycles_i`,1)+8 cycles after the clock edge that accepts the start.
- R7: While `done_o` is high and no new start or load arrives, the codes stay stable whatever the comparators do. A start accepted from this state begins a new conversion.
- R8: A `start_i` pulse during calibration or the bit decisions is ignored and does not change the timing or the results.
- R9: With `dac_mode_i` high and no conversion running, `load_i` writes `load_code_i` into all column registers, visible on `dac_code_o` one cycle later. In this mode the comparator bits and `start_i` have no effect.
- R10: An accepted load drops `done_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a row conversion |
| cal_cycles_i | input | CAL_W | Calibration window length in cycles (0 is treated as 1) |
| dac_mode_i | input | 1 | 1 selects digital-to-analog input mode |
| load_i | input | 1 | Load codes in DAC-input mode |
| load_code_i | input | N_COLS*RES_W | Row of codes to load |
| cmp_i | input | N_COLS | Per-column comparator decision |
| dac_code_o | output | N_COLS*RES_W | Per-column DAC code |
| cal_o | output | 1 | Calibration window active |
| busy_o | output | 1 | Calibration or bit decisions running |
| done_o | output | 1 | Conversion results valid |

## Verification
Assertions check several properties on every cycle:
- Only one bit position is in trial and only one is being resolved.
- The decision phase only moves on or finishes.
- A calibration window opens whenever the block becomes busy.
- The calibration counter stays inside its window.
- Held results and loaded codes keep their values.
- An accepted start clears the row.

Only the bench scenarios can show the conversion itself. They check that the final codes match each column's input across several row patterns, and that every intermediate trial code is correct. They also check the exact done latency for different calibration lengths, and that a start in the middle of a conversion, comparator activity in input mode, and comparator changes after completion all leave the codes as they were.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAL  = 2'd1,
    ST_CONV = 2'd2,
    ST_DONE = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_cal_timer.sv
module sar_cal_timer #(
  parameter int CAL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CAL_W-1:0] cal_cycles_i,
  output logic             last_o
);
  logic [CAL_W-1:0] cnt_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= CAL_W'(1);
    end else if (clr_i) begin
      cnt_q <= '0;
      len_q <= (cal_cycles_i == '0) ? CAL_W'(1) : cal_cycles_i;
    end else if (run_i) begin
      cnt_q <= cnt_q + CAL_W'(1);
    end
  end

  assign last_o = run_i && (cnt_q == len_q - CAL_W'(1));

  assert_cal_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_q));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W = 8,
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dac_mode_i,
  input  logic             load_i,
  input  logic             cal_last_i,
  output logic             clr_o,
  output logic             load_o,
  output logic             cal_run_o,
  output logic [RES_W-1:0] trial_sel_o,
  output logic [RES_W-1:0] resolve_sel_o,
  output logic             busy_o,
  output logic             done_o
);
  sar_state_e state_q, state_d;
  logic [IDX_W-1:0] bit_q;
  logic idle_like;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign clr_o     = idle_like && start_i && !dac_mode_i;
  assign load_o    = idle_like && load_i && dac_mode_i;
  assign cal_run_o = (state_q == ST_CAL);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (clr_o)       state_d = ST_CAL;
        else if (load_o) state_d = ST_IDLE;
      end
      ST_CAL:  if (cal_last_i) state_d = ST_CONV;
      ST_CONV: if (bit_q == '0) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CAL && cal_last_i) bit_q <= IDX_W'(RES_W - 1);
      else if (state_q == ST_CONV && bit_q != '0) bit_q <= bit_q - IDX_W'(1);
    end
  end

  // trial bit is armed one edge ahead of its decision cycle
  always_comb begin
    trial_sel_o   = '0;
    resolve_sel_o = '0;
    if (state_q == ST_CAL && cal_last_i)
      trial_sel_o = RES_W'(1) << (RES_W - 1);
    if (state_q == ST_CONV) begin
      resolve_sel_o = RES_W'(1) << bit_q;
      if (bit_q != '0) trial_sel_o = RES_W'(1) << (bit_q - IDX_W'(1));
    end
  end

  assign busy_o = (state_q == ST_CAL) || (state_q == ST_CONV);
  assign done_o = (state_q == ST_DONE);

  assert_trial_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trial_sel_o));
  assert_resolve_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(resolve_sel_o));
  assert_conv_progress_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |=> (state_q == ST_CONV || state_q == ST_DONE));
  assert_cal_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> cal_run_o);
endmodule

// File: rtl/sar_col.sv
module sar_col #(
  parameter int RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [RES_W-1:0] load_val_i,
  input  logic [RES_W-1:0] trial_sel_i,
  input  logic [RES_W-1:0] resolve_sel_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o
);
  for (genvar b = 0; b < RES_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               code_o[b] <= 1'b0;
      else if (clr_i)            code_o[b] <= 1'b0;
      else if (load_i)           code_o[b] <= load_val_i[b];
      else if (resolve_sel_i[b]) code_o[b] <= cmp_i;
      else if (trial_sel_i[b])   code_o[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_row_ctrl.sv
module sar_row_ctrl #(
  parameter int N_COLS = 128,
  parameter int RES_W  = 8,
  parameter int CAL_W  = 8,
  localparam int ROW_W = N_COLS * RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CAL_W-1:0] cal_cycles_i,
  input  logic             dac_mode_i,
  input  logic             load_i,
  input  logic [ROW_W-1:0] load_code_i,
  input  logic [N_COLS-1:0] cmp_i,
  output logic [ROW_W-1:0] dac_code_o,
  output logic             cal_o,
  output logic             busy_o,
  output logic             done_o
);
  logic clr, load, cal_run, cal_last;
  logic [RES_W-1:0] trial_sel, resolve_sel;

  sar_cal_timer #(.CAL_W(CAL_W)) u_cal (
    .clk_i, .rst_ni,
    .clr_i        (clr),
    .run_i        (cal_run),
    .cal_cycles_i (cal_cycles_i),
    .last_o       (cal_last)
  );

  sar_seq #(.RES_W(RES_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i       (start_i),
    .dac_mode_i    (dac_mode_i),
    .load_i        (load_i),
    .cal_last_i    (cal_last),
    .clr_o         (clr),
    .load_o        (load),
    .cal_run_o     (cal_run),
    .trial_sel_o   (trial_sel),
    .resolve_sel_o (resolve_sel),
    .busy_o        (busy_o),
    .done_o        (done_o)
  );

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    sar_col #(.RES_W(RES_W)) u_col (
      .clk_i, .rst_ni,
      .clr_i         (clr),
      .load_i        (load),
      .load_val_i    (load_code_i[c*RES_W +: RES_W]),
      .trial_sel_i   (trial_sel),
      .resolve_sel_i (resolve_sel),
      .cmp_i         (cmp_i[c]),
      .code_o        (dac_code_o[c*RES_W +: RES_W])
    );
  end

  assign cal_o = cal_run;

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !dac_mode_i && !busy_o) |=> (dac_code_o == '0 && cal_o));
  assert_hold_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i && !load_i) |=> $stable(dac_code_o));
  assert_load_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_mode_i && load_i && !busy_o) |=> (dac_code_o == $past(load_code_i)));
  assert_dac_mode_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_mode_i && !load_i && !busy_o) |=> $stable(dac_code_o));
  assert_load_drops_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_mode_i && load_i && !busy_o) |=> !done_o);
endmodule

// File: tb/tb_sar_row_ctrl.sv
module tb_sar_row_ctrl;
  localparam int N = 128;
  localparam int RW = 8;
  localparam int CW = 8;

  logic clk_i = 0, rst_ni = 0;
  logic start_i = 0, dac_mode_i = 0, load_i = 0;
  logic [CW-1:0] cal_cycles_i = '0;
  logic [N*RW-1:0] load_code_i = '0;
  logic [N-1:0] cmp_i;
  logic [N*RW-1:0] dac_code_o;
  logic cal_o, busy_o, done_o;
  logic [RW-1:0] vin [N];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  sar_row_ctrl #(.N_COLS(N), .RES_W(RW), .CAL_W(CW)) dut (.*);

  // ideal comparator model
  always_comb
    for (int c = 0; c < N; c++)
      cmp_i[c] = (vin[c] >= dac_code_o[c*RW +: RW]);

  function automatic logic [RW-1:0] code_of(int c);
    return dac_code_o[c*RW +: RW];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_vin(int kind);
    for (int c = 0; c < N; c++)
      case (kind)
        0: vin[c] = RW'(c * 2);
        1: vin[c] = 8'hFF;
        2: vin[c] = 8'h00;
        3: vin[c] = (c % 2) ? 8'hAA : 8'h55;
        default: vin[c] = RW'(c * 37 + 11);
      endcase
  endtask

  task automatic check_row(string req);
    int bad = 0, first = -1;
    for (int c = 0; c < N; c++)
      if (code_of(c) != vin[c]) begin
        bad++;
        if (first < 0) first = c;
      end
    if (first < 0) chk(1, req, "row codes", 0, 0);
    else chk(0, req, "row code col", int'(code_of(first)), int'(vin[first]));
  endtask

  task automatic pulse_start();
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic t_reset();
    int nz = 0;
    for (int c = 0; c < N; c++) if (code_of(c) != 0) nz++;
    chk(nz == 0, "R1", "nonzero codes after reset", nz, 0);
    chk(!busy_o && !done_o && !cal_o, "R1", "status after reset",
        {busy_o, done_o, cal_o}, 0);
  endtask

  // full conversion with stepwise checks
  task automatic t_convert(int cal, int kind, bit mid_start);
    int len = (cal == 0) ? 1 : cal;
    cal_cycles_i = CW'(cal);
    set_vin(kind);
    pulse_start();
    for (int i = 0; i < len; i++) begin
      chk(cal_o && busy_o, "R2", "cal window", cal_o, 1);
      chk(code_of(0) == 0 && code_of(N-1) == 0, "R2", "codes during cal",
          code_of(0), 0);
      if (mid_start && i == 0) begin
        start_i = 1;
        @(negedge clk_i);
        start_i = 0;
      end else @(negedge clk_i);
    end
    for (int s = 0; s < RW; s++) begin
      int sh = RW - s;
      int exp = ((int'(vin[N-1]) >> sh) << sh) | (1 << (RW - 1 - s));
      chk(!cal_o && busy_o && !done_o, "R3", "decision phase flags", cal_o, 0);
      chk(code_of(N-1) == exp, "R3", "trial code", code_of(N-1), exp);
      @(negedge clk_i);
    end
    chk(done_o && !busy_o, "R6", "done after cal+8", done_o, 1);
    check_row(mid_start ? "R8" : "R4");
    check_row("R5");
  endtask

  task automatic t_hold();
    logic [N*RW-1:0] snap = dac_code_o;
    for (int c = 0; c < N; c++) vin[c] = ~vin[c];
    repeat (6) @(negedge clk_i);
    chk(dac_code_o == snap && done_o, "R7", "hold after done", done_o, 1);
  endtask

  task automatic t_dac_mode();
    logic [N*RW-1:0] pat;
    for (int c = 0; c < N; c++) pat[c*RW +: RW] = RW'(255 - c);
    dac_mode_i = 1;
    load_code_i = pat;
    load_i = 1;
    @(negedge clk_i);
    load_i = 0;
    chk(dac_code_o == pat, "R9", "loaded code col0", code_of(0), 255);
    chk(!done_o, "R10", "done after load", done_o, 0);
    for (int c = 0; c < N; c++) vin[c] = RW'(c);
    pulse_start();
    repeat (3) @(negedge clk_i);
    chk(dac_code_o == pat && !busy_o, "R9", "codes after cmp/start in dac mode",
        busy_o, 0);
    dac_mode_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_convert(0, 0, 0);
    t_hold();
    t_convert(3, 1, 0);
    t_convert(20, 2, 0);
    t_convert(5, 3, 1);
    t_convert(2, 4, 0);
    t_dac_mode();
    t_convert(1, 0, 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule